// File: doc/BRIEF.md
# Two-Wire Debug Command Receiver

This block is the target side of a two-wire serial debug port. A clock pin and a bidirectional data pin, both driven by an external host, are brought onto the system clock through two-flop synchronizers. Edges of the debug clock are then detected from the synchronized copies. Until debug mode has been entered, both pins are ordinary general-purpose I/O and the port ignores them. Debug mode is entered when the host gives two rising edges on the clock pin while the external reset pin is held low. Once entered, debug mode stays on until the system power-on reset is asserted.

In debug mode the host sends commands most significant bit first. The host changes the data pin on the rising edge of the debug clock, and the receiver samples it on the falling edge. The first byte of a command holds three fields: a five-bit instruction code, a flag asking for a response byte, and a count of 0 to 3 operand bytes that follow. When the last operand has arrived, the command is passed to a backend as a one-cycle strobe. If a response was asked for, the backend hands back one byte, and the port shifts it out on the shared data pin during the next eight debug clocks.

A lock input limits which commands may run. While the lock input is low, only three instruction codes reach the backend. Every other command is still framed in full, so its operands are consumed, and it answers with a zero byte if it asked for a response.

Top module: `dbg_wire_port`

## Requirements
- R1: `dbg_active` rises after the second synchronized rising edge of `dclk_pin` seen while `pin_rst_n` is low. If `pin_rst_n` goes high after only one edge, the edge count is cleared and the port stays inactive.
- R2: While `dbg_active` is 0, activity on `dclk_pin` and `ddat_in` produces no `cmd_valid` and never asserts `ddat_oe`.
- R3: In debug mode, `ddat_in` is sampled on each falling edge of `dclk_pin`, most significant bit first. The first byte of a command is decoded as follows: bits 7..3 are the opcode, bit 2 set requests a response, and bits 1..0 give the operand count. `cmd_valid` pulses for exactly one cycle after the last byte of the command, with `cmd_op`, `cmd_rsp` and `cmd_nargs` taken from the first byte.
- R4: Operand bytes appear on `cmd_args` in arrival order: the first in bits 7..0, the second in bits 15..8, the third in bits 23..16. Bytes that were not sent read as zero.
- R5: After an accepted command that requests a response, the byte presented with `resp_ready` is driven on `ddat_out` MSB first. Bit 7 is driven from the first rising edge of `dclk_pin`, and the next bit from each later rising edge. `ddat_oe` is high from the first rising edge until the eighth falling edge, and low otherwise.
- R6: While `lock_n` is 0, only opcodes 5'h0C (erase), 5'h06 (status) and 5'h1A (identity) produce `cmd_valid`. While `lock_n` is 1, every opcode does.
- R7: A rejected command still consumes its operand bytes, so the next command is framed correctly. If it requested a response, the port returns 8'h00.
- R8: Once set, `dbg_active` stays high through any later activity on `pin_rst_n` and is cleared only by `por_n` going low.
- R9: In debug mode, `dclk_pin` edges are not shifted in as command bits while `pin_rst_n` is low.
- R10: While `por_n` is low, `dbg_active`, `ddat_oe`, `ddat_out` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| dclk_pin | input | 1 | Debug clock from the host |
| ddat_in | input | 1 | Input side of the debug data pin |
| ddat_out | output | 1 | Output side of the debug data pin |
| ddat_oe | output | 1 | Output enable for the debug data pin |
| lock_n | input | 1 | Debug lock; 0 restricts commands to the allowed set |
| dbg_active | output | 1 | Debug mode entered |
| cmd_valid | output | 1 | One-cycle strobe for a complete, accepted command |
| cmd_op | output | 5 | Instruction code |
| cmd_rsp | output | 1 | Command requests a response byte |
| cmd_nargs | output | 2 | Number of operand bytes |
| cmd_args | output | 24 | Operand bytes, first in the low byte, unused bytes zero |
| resp_data | input | 8 | Response byte from the backend |
| resp_ready | input | 1 | Strobe marking resp_data valid |

## Verification
The assertions check several rules on every cycle. The output enable is never asserted outside debug mode, and no command strobe appears before entry. The strobe is always a single cycle, debug mode never drops without a power-on reset, and no strobe carries a forbidden opcode while the lock was low. Other behaviour can only be shown by the bench's scenarios, because it depends on a whole exchange over the pins. This covers entry on exactly two edges, field decoding and operand ordering, operands that a rejected command consumes, the zero response from a rejected command, and the bit order of a response.

// File: rtl/dbg_wire_port.sv
module dbg_wire_port #(
  parameter int         SYNC_STAGES = 2,
  parameter int         ENTRY_EDGES = 2,
  parameter logic [4:0] OP_ERASE    = 5'h0C,
  parameter logic [4:0] OP_STATUS   = 5'h06,
  parameter logic [4:0] OP_CHIPID   = 5'h1A
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        pin_rst_n,
  input  logic        dclk_pin,
  input  logic        ddat_in,
  output logic        ddat_out,
  output logic        ddat_oe,
  input  logic        lock_n,
  output logic        dbg_active,
  output logic        cmd_valid,
  output logic [4:0]  cmd_op,
  output logic        cmd_rsp,
  output logic [1:0]  cmd_nargs,
  output logic [23:0] cmd_args,
  input  logic [7:0]  resp_data,
  input  logic        resp_ready
);

  localparam int EW = $clog2(ENTRY_EDGES + 1);

  typedef enum logic [1:0] {S_RX, S_WAIT, S_TX} state_t;

  logic [SYNC_STAGES-1:0] ck_sy, dt_sy, rs_sy;
  logic ck_q, ck_s, dt_s, rs_s, rise, fall, run;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      ck_sy <= '0;
      dt_sy <= '0;
      rs_sy <= '0;
      ck_q  <= 1'b0;
    end else begin
      ck_sy <= {ck_sy[SYNC_STAGES-2:0], dclk_pin};
      dt_sy <= {dt_sy[SYNC_STAGES-2:0], ddat_in};
      rs_sy <= {rs_sy[SYNC_STAGES-2:0], pin_rst_n};
      ck_q  <= ck_sy[SYNC_STAGES-1];
    end

  assign ck_s = ck_sy[SYNC_STAGES-1];
  assign dt_s = dt_sy[SYNC_STAGES-1];
  assign rs_s = rs_sy[SYNC_STAGES-1];
  assign rise = ck_s & ~ck_q;
  assign fall = ~ck_s & ck_q;
  assign run  = dbg_active & rs_s;

  logic [EW-1:0] ent_cnt;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      dbg_active <= 1'b0;
      ent_cnt    <= '0;
    end else if (!dbg_active) begin
      if (rs_s) ent_cnt <= '0;
      else if (rise) begin
        if (ent_cnt == EW'(ENTRY_EDGES - 1)) dbg_active <= 1'b1;
        ent_cnt <= ent_cnt + 1'b1;
      end
    end

  state_t      st;
  logic [2:0]  bit_cnt;
  logic [1:0]  byte_idx, n_r;
  logic [6:0]  rx_sh;
  logic [4:0]  op_r;
  logic        rsp_r, oe_r;
  logic [23:0] args_r, args_nx;
  logic [7:0]  tx_sh, rx_byte;
  logic        first, last, fin_ok, fin_rsp;
  logic [4:0]  fin_op;
  logic [1:0]  fin_n;

  assign rx_byte = {rx_sh, dt_s};
  assign first   = (byte_idx == 2'd0);
  assign fin_op  = first ? rx_byte[7:3] : op_r;
  assign fin_rsp = first ? rx_byte[2]   : rsp_r;
  assign fin_n   = first ? rx_byte[1:0] : n_r;
  assign last    = first ? (rx_byte[1:0] == 2'd0) : (byte_idx == n_r);
  assign fin_ok  = lock_n | (fin_op == OP_ERASE) | (fin_op == OP_STATUS) | (fin_op == OP_CHIPID);

  always_comb begin
    args_nx = first ? '0 : args_r;
    case (byte_idx)
      2'd1:    args_nx[7:0]   = rx_byte;
      2'd2:    args_nx[15:8]  = rx_byte;
      2'd3:    args_nx[23:16] = rx_byte;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      st        <= S_RX;
      bit_cnt   <= '0;
      byte_idx  <= '0;
      rx_sh     <= '0;
      op_r      <= '0;
      rsp_r     <= 1'b0;
      n_r       <= '0;
      args_r    <= '0;
      tx_sh     <= '0;
      oe_r      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_rsp   <= 1'b0;
      cmd_nargs <= '0;
      cmd_args  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      case (st)
        S_RX:
          if (run && fall) begin
            rx_sh   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              op_r   <= fin_op;
              rsp_r  <= fin_rsp;
              n_r    <= fin_n;
              args_r <= args_nx;
              if (last) begin
                byte_idx  <= '0;
                cmd_valid <= fin_ok;
                if (fin_ok) begin
                  cmd_op    <= fin_op;
                  cmd_rsp   <= fin_rsp;
                  cmd_nargs <= fin_n;
                  cmd_args  <= args_nx;
                end
                if (fin_rsp) begin
                  if (fin_ok) st <= S_WAIT;
                  else begin
                    tx_sh <= 8'h00;
                    st    <= S_TX;
                  end
                end
              end else begin
                byte_idx <= byte_idx + 2'd1;
              end
            end
          end
        S_WAIT:
          if (resp_ready) begin
            tx_sh <= resp_data;
            st    <= S_TX;
          end
        S_TX: begin
          if (run && rise) begin
            if (!oe_r) oe_r <= 1'b1;
            else tx_sh <= {tx_sh[6:0], 1'b0};
          end
          if (run && fall && oe_r) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              oe_r <= 1'b0;
              st   <= S_RX;
            end
          end
        end
        default: st <= S_RX;
      endcase
    end

  assign ddat_oe  = oe_r;
  assign ddat_out = oe_r & tx_sh[7];

endmodule

// File: rtl/dbg_wire_port_chk.sv
module dbg_wire_port_chk (
  input logic       clk,
  input logic       por_n,
  input logic       lock_n,
  input logic       ddat_oe,
  input logic       dbg_active,
  input logic       cmd_valid,
  input logic [4:0] cmd_op
);

  AST_OE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!por_n)
    ddat_oe |-> dbg_active); // R2

  AST_NO_CMD_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    !dbg_active |-> !cmd_valid); // R2

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!por_n)
    cmd_valid |=> !cmd_valid); // R3

  AST_LOCK_FILTER: assert property (@(posedge clk) disable iff (!por_n)
    cmd_valid |-> ($past(lock_n) || (cmd_op inside {5'h0C, 5'h06, 5'h1A}))); // R6

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    dbg_active |=> dbg_active); // R8

endmodule

bind dbg_wire_port dbg_wire_port_chk chk_i (.*);

// File: tb/dbg_wire_port_test.sv
`timescale 1ns/1ps
module dbg_wire_port_test;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        pin_rst_n = 1'b1;
  logic        dclk_pin = 1'b0;
  logic        ddat_in = 1'b0;
  logic        lock_n = 1'b1;
  logic [7:0]  resp_data = 8'h00;
  logic        resp_ready = 1'b0;
  logic        ddat_out, ddat_oe, dbg_active, cmd_valid, cmd_rsp;
  logic [4:0]  cmd_op;
  logic [1:0]  cmd_nargs;
  logic [23:0] cmd_args;

  int   n_chk = 0, n_bad = 0, cap_cnt = 0;
  logic [4:0]  cap_op;
  logic        cap_rsp;
  logic [1:0]  cap_n;
  logic [23:0] cap_args;
  bit   done = 0;

  always #5 clk = ~clk;

  dbg_wire_port uut (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .dclk_pin(dclk_pin),
    .ddat_in(ddat_in), .ddat_out(ddat_out), .ddat_oe(ddat_oe), .lock_n(lock_n),
    .dbg_active(dbg_active), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_rsp(cmd_rsp), .cmd_nargs(cmd_nargs), .cmd_args(cmd_args),
    .resp_data(resp_data), .resp_ready(resp_ready)
  );

  function automatic logic [7:0] model(input logic [4:0] op, input logic [23:0] a);
    return {op, 3'b101} ^ a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic bit allowed(input logic [4:0] op);
    return op == 5'h0C || op == 5'h06 || op == 5'h1A;
  endfunction

  function automatic logic [23:0] mask(input logic [23:0] a, input logic [1:0] n);
    return a & ((24'h1 << (8 * n)) - 24'h1);
  endfunction

  always @(negedge clk) begin
    resp_ready = 1'b0;
    if (cmd_valid) begin
      cap_cnt++;
      cap_op = cmd_op; cap_rsp = cmd_rsp; cap_n = cmd_nargs; cap_args = cmd_args;
      if (cmd_rsp) begin
        resp_data  = model(cmd_op, cmd_args);
        resp_ready = 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clk(input logic d);
    ddat_in = d; dclk_pin = 1'b1; wcyc(H);
    dclk_pin = 1'b0; wcyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse_clk(b[i]);
  endtask

  task automatic read_byte(output logic [7:0] b, output bit oe_ok);
    oe_ok = 1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      dclk_pin = 1'b1; wcyc(H);
      b = {b[6:0], ddat_out};
      if (ddat_oe !== 1'b1) oe_ok = 0;
      dclk_pin = 1'b0; wcyc(H);
    end
  endtask

  task automatic do_cmd(input logic [4:0] op, input logic rsp, input logic [1:0] n,
                        input logic [23:0] a, input logic lk);
    int c0;
    bit ok, oe_ok;
    logic [23:0] am;
    logic [7:0] rb;
    lock_n = lk;
    c0 = cap_cnt;
    am = mask(a, n);
    send_byte({op, rsp, n});
    for (int k = 0; k < n; k++) send_byte(am[8*k +: 8]);
    ok = lk || allowed(op);
    if (ok) begin
      check("R3 strobe count", cap_cnt, c0 + 1);
      check("R3 opcode", cap_op, op);
      check("R3 response flag", cap_rsp, rsp);
      check("R3 operand count", cap_n, n);
      check("R4 operands", cap_args, am);
    end else begin
      check("R6 locked opcode blocked", cap_cnt, c0);
    end
    if (rsp) begin
      read_byte(rb, oe_ok);
      if (ok) check("R5 response byte", rb, model(op, am));
      else    check("R7 rejected response zero", rb, 8'h00);
      check("R5 oe during response", oe_ok, 1);
      check("R5 oe released", ddat_oe, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] rb;
    bit oe_ok;
    int unsigned seed;
    seed = $urandom(32'd2024);
    wcyc(4);
    check("R10 active in reset", dbg_active, 0);
    check("R10 oe in reset", ddat_oe, 0);
    check("R10 data out in reset", ddat_out, 0);
    check("R10 strobe in reset", cmd_valid, 0);
    por_n = 1'b1; wcyc(4);

    send_byte(8'h1C); send_byte(8'hAA); read_byte(rb, oe_ok);
    check("R2 no strobe before entry", cap_cnt, 0);
    check("R2 oe never high before entry", oe_ok, 0);
    check("R2 still inactive", dbg_active, 0);

    pin_rst_n = 1'b0; wcyc(H); pulse_clk(1'b0);
    pin_rst_n = 1'b1; wcyc(H);
    check("R1 one edge insufficient", dbg_active, 0);
    pin_rst_n = 1'b0; wcyc(H); pulse_clk(1'b0);
    check("R1 inactive after first edge", dbg_active, 0);
    pulse_clk(1'b0);
    check("R1 active after second edge", dbg_active, 1);
    pulse_clk(1'b1); pulse_clk(1'b1); pulse_clk(1'b0);
    pin_rst_n = 1'b1; wcyc(H);
    do_cmd(5'h11, 1'b1, 2'd2, 24'h00BEEF, 1'b1);
    check("R9 framing after held-reset edges", cap_op, 5'h11);

    pin_rst_n = 1'b0; wcyc(2 * H); pin_rst_n = 1'b1; wcyc(H);
    check("R8 active after pin reset", dbg_active, 1);
    do_cmd(5'h03, 1'b0, 2'd3, 24'h123456, 1'b1);
    do_cmd(5'h1F, 1'b1, 2'd0, 24'h0, 1'b1);
    do_cmd(5'h06, 1'b1, 2'd0, 24'h0, 1'b0);
    do_cmd(5'h10, 1'b1, 2'd2, 24'h00F0F0, 1'b0);
    do_cmd(5'h0C, 1'b0, 2'd1, 24'h000077, 1'b0);
    check("R7 framing after rejected command", cap_op, 5'h0C);
    do_cmd(5'h1A, 1'b1, 2'd3, 24'hFFFFFF, 1'b0);

    for (int t = 0; t < 40; t++) begin
      logic [4:0] op;
      logic lk;
      lk = ($urandom % 3) != 0;
      op = $urandom;
      if (!lk && ($urandom % 2)) begin
        case ($urandom % 3)
          0: op = 5'h0C;
          1: op = 5'h06;
          default: op = 5'h1A;
        endcase
      end
      do_cmd(op, 1'($urandom), 2'($urandom), 24'($urandom), lk);
    end

    por_n = 1'b0; wcyc(2);
    check("R8 power-on reset clears mode", dbg_active, 0);
    check("R10 oe after power-on reset", ddat_oe, 0);
    summary();
  end

endmodule